// File: doc/BRIEF.md
# Configuration Port FIFO Bridge

This block is a register-mapped peripheral that moves 32-bit words between a processor bus and a word-wide configuration port. Software loads configuration words into a write queue, then writes a command bit. The block then drains the queue onto the port through a valid/ready handshake. For readback, software programs a word count and issues a second command bit. The block then accepts exactly that many words from the port into a read queue, which software empties through a data register.

Software polls progress through a status register with a done flag, and through vacancy and occupancy counts. An interrupt line reports queue conditions: write queue empty, write queue half full, read queue half full and read queue full. Each condition latches when it rises, and software clears it by writing 1 to its bit. Two level-sensitive control bits act for as long as they are held set. One flushes both queues. The other returns the whole block to its reset state.

Bus reads are combinational on `busAddr`. Any read or write strobe takes effect on the rising clock edge where it is sampled.

Top module: `cfgport_fifo_bridge`

## Requirements
- R1: After reset, status (0x110) bit 0 reads 1. Vacancy (0x114) reads the write-queue depth, 1024. Occupancy (0x118) and interrupt status (0x20) read 0. `irq`, `cfgOutValid` and `cfgInReady` are low.
- R2: A write to 0x100 appends one word to the write queue and lowers vacancy by one. A write to 0x100 while the queue holds 1024 words is discarded.
- R3: A write to control (0x10C) with bit 0 set, while idle, starts a drain. Words leave on `cfgOutData` in write order, one per cycle where `cfgOutValid` and `cfgOutReady` are both high. Status bit 0 reads 0 until the queue is empty and 1 afterwards.
- R4: Size (0x108) keeps the low 12 bits of the written value. A control write with bit 1 set, while idle, starts a readback that accepts exactly that many words, then sets status bit 0.
- R5: During readback, `cfgInReady` is high only while the read queue holds fewer than 256 words. Readback pauses when the queue is full and resumes when software reads from it. Occupancy reports the queued count.
- R6: A read of 0x104 returns the oldest read-queue word and removes it. A read of an empty read queue returns 0.
- R7: While control bit 2 is set, both queues are held empty.
- R8: While control bit 3 is set, the block returns to its reset state. Both queues are empty, the transfer is idle, and size, interrupt enable, interrupt status and the global enable all read 0.
- R9: Interrupt status bits are: bit 3 read queue full, bit 2 write queue empty, bit 1 read queue at 128 words or more, bit 0 write queue at 512 words or more. A bit sets when its condition rises. Writing 1 to a bit clears it.
- R10: `irq` is high exactly when global enable (0x1C) bit 31 is set and some status bit is set whose bit in interrupt enable (0x28) is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 12 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational on busAddr |
| irq | output | 1 | Interrupt request |
| cfgOutValid | output | 1 | Drain word valid toward the port |
| cfgOutData | output | 32 | Drain word |
| cfgOutReady | input | 1 | Port accepts the drain word |
| cfgInValid | input | 1 | Port offers a readback word |
| cfgInData | input | 32 | Readback word |
| cfgInReady | output | 1 | Block accepts the readback word |

## Verification
The assertions assume the bus raises at most one of `busWrEn` and `busRdEn` per cycle, and that both strobes and the port handshake inputs change only away from the rising edge. The bench drives every input on the falling edge and issues one bus operation at a time. Randomness in the bench is limited to port throttling, data values and transfer lengths. Each readback length stays at or below the read-queue depth, except in the directed case that exercises back-pressure.

// File: rtl/cfgbr_pkg.sv
package cfgbr_pkg;

  localparam int OFF_GIE  = 'h01C;
  localparam int OFF_ISR  = 'h020;
  localparam int OFF_IER  = 'h028;
  localparam int OFF_WF   = 'h100;
  localparam int OFF_RF   = 'h104;
  localparam int OFF_SIZE = 'h108;
  localparam int OFF_CTRL = 'h10C;
  localparam int OFF_STAT = 'h110;
  localparam int OFF_VAC  = 'h114;
  localparam int OFF_OCC  = 'h118;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONFIG,
    ST_READBACK
  } xferState_t;

  typedef struct packed {
    logic wfPush;
    logic wfPop;
    logic rfPush;
    logic rfPop;
    logic clear;
  } dpStrobes_t;

endpackage

// File: rtl/cfgbr_fifo.sv
module cfgbr_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic [CW-1:0]    count,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic full, pushOk, popOk;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign pushOk  = push && !full;
  assign popOk   = pop && !empty;
  assign popData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk)  rdPtr <= nextPtr(rdPtr);
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

endmodule

// File: rtl/cfgbr_datapath.sv
module cfgbr_datapath
  import cfgbr_pkg::*;
#(
  parameter int WR_DEPTH = 1024,
  parameter int RD_DEPTH = 256,
  localparam int WR_CW = $clog2(WR_DEPTH) + 1,
  localparam int RD_CW = $clog2(RD_DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strobes,
  input  logic [31:0]      busWdata,
  input  logic [31:0]      cfgInData,
  output logic [31:0]      wfHead,
  output logic [31:0]      rfHead,
  output logic [WR_CW-1:0] wfCount,
  output logic             wfEmpty,
  output logic [RD_CW-1:0] rfCount,
  output logic             rfEmpty
);

  cfgbr_fifo #(.WIDTH(32), .DEPTH(WR_DEPTH)) u_wrQ (
    .clk(clk), .rstN(rstN), .clear(strobes.clear),
    .push(strobes.wfPush), .pushData(busWdata),
    .pop(strobes.wfPop), .popData(wfHead),
    .count(wfCount), .empty(wfEmpty)
  );

  cfgbr_fifo #(.WIDTH(32), .DEPTH(RD_DEPTH)) u_rdQ (
    .clk(clk), .rstN(rstN), .clear(strobes.clear),
    .push(strobes.rfPush), .pushData(cfgInData),
    .pop(strobes.rfPop), .popData(rfHead),
    .count(rfCount), .empty(rfEmpty)
  );

endmodule

// File: rtl/cfgbr_ctrl.sv
module cfgbr_ctrl
  import cfgbr_pkg::*;
#(
  parameter int WR_DEPTH = 1024,
  parameter int RD_DEPTH = 256,
  parameter int ADDR_W   = 12,
  parameter int SIZE_W   = 12,
  localparam int WR_CW = $clog2(WR_DEPTH) + 1,
  localparam int RD_CW = $clog2(RD_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [SIZE_W-1:0] wdataLo,
  input  logic              wdataMsb,
  output logic [31:0]       busRdata,
  output logic              irq,
  output logic              cfgOutValid,
  input  logic              cfgOutReady,
  input  logic              cfgInValid,
  output logic              cfgInReady,
  input  logic [WR_CW-1:0]  wfCount,
  input  logic              wfEmpty,
  input  logic [RD_CW-1:0]  rfCount,
  input  logic              rfEmpty,
  input  logic [31:0]       rfHead,
  output dpStrobes_t        strobes
);

  localparam logic [ADDR_W-1:0] A_GIE  = ADDR_W'(OFF_GIE);
  localparam logic [ADDR_W-1:0] A_ISR  = ADDR_W'(OFF_ISR);
  localparam logic [ADDR_W-1:0] A_IER  = ADDR_W'(OFF_IER);
  localparam logic [ADDR_W-1:0] A_WF   = ADDR_W'(OFF_WF);
  localparam logic [ADDR_W-1:0] A_RF   = ADDR_W'(OFF_RF);
  localparam logic [ADDR_W-1:0] A_SIZE = ADDR_W'(OFF_SIZE);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_VAC  = ADDR_W'(OFF_VAC);
  localparam logic [ADDR_W-1:0] A_OCC  = ADDR_W'(OFF_OCC);
  localparam logic [WR_CW-1:0]  WR_HALF = WR_CW'(WR_DEPTH / 2);
  localparam logic [RD_CW-1:0]  RD_HALF = RD_CW'(RD_DEPTH / 2);
  localparam logic [3:0]        COND_AT_RESET = 4'b0100;

  xferState_t        state;
  logic [SIZE_W-1:0] sizeReg, remaining;
  logic              gie, clrLvl, rstLvl, rfFull;
  logic [3:0]        ier, isr, cond, condPrev, isrW1c;
  logic wrGie, wrIsr, wrIer, wrWf, wrSize, wrCtrl, rdRf;

  assign wrGie  = busWrEn && (busAddr == A_GIE);
  assign wrIsr  = busWrEn && (busAddr == A_ISR);
  assign wrIer  = busWrEn && (busAddr == A_IER);
  assign wrWf   = busWrEn && (busAddr == A_WF);
  assign wrSize = busWrEn && (busAddr == A_SIZE);
  assign wrCtrl = busWrEn && (busAddr == A_CTRL);
  assign rdRf   = busRdEn && (busAddr == A_RF);

  assign rfFull      = (rfCount == RD_CW'(RD_DEPTH));
  assign cond        = {rfFull, wfEmpty, rfCount >= RD_HALF, wfCount >= WR_HALF};
  assign isrW1c      = wrIsr ? wdataLo[3:0] : 4'b0000;
  assign cfgOutValid = (state == ST_CONFIG) && !wfEmpty;
  assign cfgInReady  = (state == ST_READBACK) && !rfFull && (remaining != '0);
  assign irq         = gie && |(isr & ier);

  always_comb begin
    strobes.wfPush = wrWf;
    strobes.wfPop  = cfgOutValid && cfgOutReady;
    strobes.rfPush = cfgInValid && cfgInReady;
    strobes.rfPop  = rdRf;
    strobes.clear  = clrLvl || rstLvl;
  end

  always_comb begin
    case (busAddr)
      A_GIE:   busRdata = {gie, 31'b0};
      A_ISR:   busRdata = {28'b0, isr};
      A_IER:   busRdata = {28'b0, ier};
      A_RF:    busRdata = rfEmpty ? 32'b0 : rfHead;
      A_SIZE:  busRdata = 32'(sizeReg);
      A_CTRL:  busRdata = {28'b0, rstLvl, clrLvl, state == ST_READBACK, state == ST_CONFIG};
      A_STAT:  busRdata = {31'b0, state == ST_IDLE};
      A_VAC:   busRdata = 32'(WR_DEPTH) - 32'(wfCount);
      A_OCC:   busRdata = 32'(rfCount);
      default: busRdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      sizeReg   <= '0;
      remaining <= '0;
      gie       <= 1'b0;
      ier       <= '0;
      isr       <= '0;
      condPrev  <= COND_AT_RESET;
      clrLvl    <= 1'b0;
      rstLvl    <= 1'b0;
    end else begin
      condPrev <= cond;
      isr      <= (isr & ~isrW1c) | (cond & ~condPrev);
      if (wrCtrl) begin
        clrLvl <= wdataLo[2];
        rstLvl <= wdataLo[3];
      end
      if (wrGie)  gie     <= wdataMsb;
      if (wrIer)  ier     <= wdataLo[3:0];
      if (wrSize) sizeReg <= wdataLo;
      case (state)
        ST_IDLE: begin
          if (wrCtrl && wdataLo[0]) state <= ST_CONFIG;
          else if (wrCtrl && wdataLo[1]) begin
            state     <= ST_READBACK;
            remaining <= sizeReg;
          end
        end
        ST_CONFIG: if (wfEmpty) state <= ST_IDLE;
        ST_READBACK: begin
          if (remaining == '0) state <= ST_IDLE;
          else if (strobes.rfPush) begin
            remaining <= remaining - SIZE_W'(1);
            if (remaining == SIZE_W'(1)) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (rstLvl) begin
        state     <= ST_IDLE;
        remaining <= '0;
        sizeReg   <= '0;
        gie       <= 1'b0;
        ier       <= '0;
        isr       <= '0;
        condPrev  <= COND_AT_RESET;
      end
    end
  end

  // R3
  cfg_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONFIG && wfEmpty) |=> (state == ST_IDLE));

  // R4
  rb_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READBACK && remaining == '0) |=> (state == ST_IDLE));

  // R8
  swrst_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstLvl |=> (state == ST_IDLE && isr == '0 && !irq));

  // R9
  isr_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rstLvl && cond[2] && !condPrev[2]) |=> isr[2]);

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !wrIer && !wrIsr && !wrGie && !rstLvl) |=> irq);

endmodule

// File: rtl/cfgport_fifo_bridge.sv
module cfgport_fifo_bridge
  import cfgbr_pkg::*;
#(
  parameter int WR_DEPTH = 1024,
  parameter int RD_DEPTH = 256,
  parameter int ADDR_W   = 12,
  parameter int SIZE_W   = 12,
  localparam int WR_CW = $clog2(WR_DEPTH) + 1,
  localparam int RD_CW = $clog2(RD_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irq,
  output logic              cfgOutValid,
  output logic [31:0]       cfgOutData,
  input  logic              cfgOutReady,
  input  logic              cfgInValid,
  input  logic [31:0]       cfgInData,
  output logic              cfgInReady
);

  dpStrobes_t       strobes;
  logic [WR_CW-1:0] wfCount;
  logic [RD_CW-1:0] rfCount;
  logic             wfEmpty, rfEmpty;
  logic [31:0]      rfHead;

  cfgbr_ctrl #(
    .WR_DEPTH(WR_DEPTH), .RD_DEPTH(RD_DEPTH), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .wdataLo(busWdata[SIZE_W-1:0]), .wdataMsb(busWdata[31]),
    .busRdata(busRdata), .irq(irq),
    .cfgOutValid(cfgOutValid), .cfgOutReady(cfgOutReady),
    .cfgInValid(cfgInValid), .cfgInReady(cfgInReady),
    .wfCount(wfCount), .wfEmpty(wfEmpty),
    .rfCount(rfCount), .rfEmpty(rfEmpty), .rfHead(rfHead),
    .strobes(strobes)
  );

  cfgbr_datapath #(.WR_DEPTH(WR_DEPTH), .RD_DEPTH(RD_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .busWdata(busWdata), .cfgInData(cfgInData),
    .wfHead(cfgOutData), .rfHead(rfHead),
    .wfCount(wfCount), .wfEmpty(wfEmpty),
    .rfCount(rfCount), .rfEmpty(rfEmpty)
  );

endmodule

// File: tb/sim_cfgport_fifo_bridge.sv
`timescale 1ns/1ps
module sim_cfgport_fifo_bridge;

  localparam logic [11:0] A_GIE = 12'h01C, A_ISR = 12'h020, A_IER = 12'h028;
  localparam logic [11:0] A_WF = 12'h100, A_RF = 12'h104, A_SIZE = 12'h108;
  localparam logic [11:0] A_CTRL = 12'h10C, A_STAT = 12'h110, A_VAC = 12'h114, A_OCC = 12'h118;
  localparam int WRD = 1024;
  localparam int RDD = 256;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic irq, cfgOutValid, cfgInReady;
  logic [31:0] cfgOutData;
  logic cfgOutReady = 1'b0, cfgInValid = 1'b0;
  logic [31:0] cfgInData = '0;

  cfgport_fifo_bridge u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq),
    .cfgOutValid(cfgOutValid), .cfgOutData(cfgOutData), .cfgOutReady(cfgOutReady),
    .cfgInValid(cfgInValid), .cfgInData(cfgInData), .cfgInReady(cfgInReady)
  );

  int checks = 0, fails = 0;
  int outMode = 0, inMode = 0;
  int sinkCnt = 0, srcIdx = 0;
  logic [31:0] wrWords [0:2047];
  logic [31:0] sunk [0:4095];
  logic [31:0] rd;

  function automatic logic [31:0] srcWord(input int i);
    return (32'(i) * 32'h9E3779B1) ^ 32'hA5A50000;
  endfunction

  always @(negedge clk) begin
    cfgOutReady <= (outMode == 2) || (outMode == 1 && $urandom_range(0, 1) == 1);
    cfgInValid  <= (inMode == 2) || (inMode == 1 && $urandom_range(0, 1) == 1);
    cfgInData   <= srcWord(srcIdx);
  end

  always @(posedge clk) begin
    if (rstN) begin
      if (cfgOutValid && cfgOutReady) begin
        if (sinkCnt < 4096) sunk[sinkCnt] <= cfgOutData;
        sinkCnt <= sinkCnt + 1;
      end
      if (cfgInValid && cfgInReady) srcIdx <= srcIdx + 1;
    end
  end

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic waitDone(input string req);
    logic [31:0] s;
    s = '0;
    for (int t = 0; t < 4000; t++) begin
      busRead(A_STAT, s);
      if (s[0]) break;
    end
    checkEq(req, {31'b0, s[0]}, 32'd1);
  endtask

  task automatic fillWf(input int n);
    for (int k = 0; k < n; k++) begin
      wrWords[k] = $urandom;
      busWrite(A_WF, wrWords[k]);
    end
  endtask

  task automatic runConfig(input int n);
    int base;
    logic [31:0] s;
    base = sinkCnt;
    busWrite(A_CTRL, 32'h1);
    if (n >= 3) begin
      busRead(A_STAT, s);
      checkEq("R3 busy during drain", {31'b0, s[0]}, 32'd0);
    end
    waitDone("R3 done after drain");
    checkEq("R3 drained count", 32'(sinkCnt - base), 32'(n));
    for (int k = 0; k < n; k++) checkEq("R3 drain order", sunk[base + k], wrWords[k]);
  endtask

  task automatic runReadback(input int n);
    int base;
    logic [31:0] d;
    busWrite(A_SIZE, 32'(n));
    base = srcIdx;
    busWrite(A_CTRL, 32'h2);
    waitDone("R4 readback done");
    busRead(A_OCC, d);
    checkEq("R4 readback count", d, 32'(n));
    for (int k = 0; k < n; k++) begin
      busRead(A_RF, d);
      checkEq("R6 read order", d, srcWord(base + k));
    end
    busRead(A_RF, d);
    checkEq("R6 empty read is zero", d, 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n, base;
    logic [31:0] d;
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(A_STAT, d); checkEq("R1 done", d, 32'd1);
    busRead(A_VAC, d);  checkEq("R1 vacancy", d, 32'(WRD));
    busRead(A_OCC, d);  checkEq("R1 occupancy", d, 32'd0);
    busRead(A_ISR, d);  checkEq("R1 isr", d, 32'd0);
    checkEq("R1 irq/valid/ready", {29'b0, irq, cfgOutValid, cfgInReady}, 32'd0);

    // R2, R3 directed drain with random throttling
    n = $urandom_range(5, 40);
    outMode = 0;
    fillWf(n);
    busRead(A_VAC, d); checkEq("R2 vacancy after writes", d, 32'(WRD - n));
    outMode = 1;
    runConfig(n);

    // R2 full queue drops extra write
    outMode = 0;
    fillWf(WRD);
    busWrite(A_WF, 32'hDEADBEEF);
    busRead(A_VAC, d); checkEq("R2 vacancy full", d, 32'd0);
    outMode = 2;
    runConfig(WRD);

    // R4, R6 readback
    inMode = 1;
    runReadback($urandom_range(3, 30));
    busWrite(A_SIZE, 32'h0000_1005);
    busRead(A_SIZE, d); checkEq("R4 size low 12 bits", d, 32'd5);

    // R5 back-pressure with 300 words
    busWrite(A_SIZE, 32'd300);
    base = srcIdx;
    busWrite(A_CTRL, 32'h2);
    repeat (1500) @(negedge clk);
    busRead(A_OCC, d); checkEq("R5 occupancy capped", d, 32'(RDD));
    busRead(A_STAT, d); checkEq("R5 still busy", {31'b0, d[0]}, 32'd0);
    #1 checkEq("R5 ready low when full", {31'b0, cfgInReady}, 32'd0);
    for (int k = 0; k < 100; k++) begin
      busRead(A_RF, d); checkEq("R5 read while paused", d, srcWord(base + k));
    end
    waitDone("R5 resume and finish");
    busRead(A_OCC, d); checkEq("R5 occupancy after resume", d, 32'd200);
    for (int k = 100; k < 300; k++) begin
      busRead(A_RF, d); checkEq("R5 read tail", d, srcWord(base + k));
    end
    checkEq("R4 accepted exactly size", 32'(srcIdx - base), 32'd300);
    busRead(A_ISR, d); checkEq("R9 full and half bits latched", d & 32'hA, 32'hA);

    // R9, R10 interrupts
    busWrite(A_ISR, 32'hF);
    busWrite(A_IER, 32'hF);
    busWrite(A_GIE, 32'h8000_0000);
    outMode = 0;
    fillWf(8);
    busRead(A_ISR, d); checkEq("R9 no rise no bit", d, 32'd0);
    outMode = 2;
    runConfig(8);
    busRead(A_ISR, d); checkEq("R9 write empty latched", d, 32'd4);
    checkEq("R10 irq asserted", {31'b0, irq}, 32'd1);
    busWrite(A_ISR, 32'h4);
    busRead(A_ISR, d); checkEq("R9 write-one clears", d, 32'd0);
    checkEq("R10 irq clears", {31'b0, irq}, 32'd0);
    outMode = 0;
    fillWf(WRD / 2);
    busRead(A_ISR, d); checkEq("R9 write half latched", d, 32'd1);
    checkEq("R10 irq on half", {31'b0, irq}, 32'd1);
    busWrite(A_GIE, 32'h0);
    checkEq("R10 global gate", {31'b0, irq}, 32'd0);

    // R7 flush both queues
    inMode = 2;
    busWrite(A_SIZE, 32'd10);
    busWrite(A_CTRL, 32'h2);
    waitDone("R7 readback before flush");
    busRead(A_OCC, d); checkEq("R7 read queue filled", d, 32'd10);
    busWrite(A_CTRL, 32'h4);
    busWrite(A_CTRL, 32'h0);
    busRead(A_VAC, d); checkEq("R7 write queue flushed", d, 32'(WRD));
    busRead(A_OCC, d); checkEq("R7 read queue flushed", d, 32'd0);
    busRead(A_RF, d);  checkEq("R7 read after flush", d, 32'd0);
    busRead(A_ISR, d); checkEq("R9 empty rises on flush", d, 32'd5);
    busWrite(A_ISR, 32'hF);

    // R8 soft reset
    fillWf(20);
    busWrite(A_IER, 32'h3);
    busWrite(A_GIE, 32'h8000_0000);
    busWrite(A_SIZE, 32'd7);
    busWrite(A_CTRL, 32'h8);
    busWrite(A_CTRL, 32'h0);
    busRead(A_VAC, d);  checkEq("R8 write queue empty", d, 32'(WRD));
    busRead(A_IER, d);  checkEq("R8 enable cleared", d, 32'd0);
    busRead(A_GIE, d);  checkEq("R8 global cleared", d, 32'd0);
    busRead(A_ISR, d);  checkEq("R8 status cleared", d, 32'd0);
    busRead(A_SIZE, d); checkEq("R8 size cleared", d, 32'd0);
    busRead(A_STAT, d); checkEq("R8 idle", d, 32'd1);
    checkEq("R8 irq low", {31'b0, irq}, 32'd0);

    // random mix of drains and readbacks
    for (int it = 0; it < 8; it++) begin
      if ($urandom_range(0, 1) == 1) begin
        n = $urandom_range(3, 60);
        outMode = 0;
        fillWf(n);
        outMode = 1;
        runConfig(n);
      end else begin
        inMode = 1;
        runReadback($urandom_range(1, 40));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule